// File: doc/BRIEF.md
# Transmit-only Ethernet MII framer

This block is a stripped-down Ethernet transmitter for a private point-to-point link that always runs 100 Mb/s full duplex. It drives the 4-bit transmit side of an MII port in the PHY's transmit clock domain. Because the link never shares the medium, it needs no carrier sense, collision detection or backoff. It can send a frame whenever it has enough data.

An upstream byte FIFO reports how many bytes it holds and presents its oldest byte at all times. When that count reaches one full payload, the framer emits a complete frame in one pass:

- a preamble;
- a start delimiter;
- a header addressed to the broadcast address, with a source address and type field fixed at build time;
- exactly one payload's worth of FIFO bytes;
- a CRC-32 frame check sequence.

After the frame it holds the line quiet for the inter-frame gap. It starts the next frame immediately after the gap if another payload is already waiting. A typical use is streaming converter samples to a host, which picks up the raw broadcast frames.

Top module: `mii_tx_framer`

## Requirements
- R1: A synchronous reset, asserted at any point including mid-frame, forces `tx_en` and `fifo_rd` low from the next clock. The next frame after reset uses a freshly initialised CRC.
- R2: A frame starts only when `fifo_level` is at least PAYLOAD_LEN. With fewer bytes stored, `tx_en` stays low indefinitely.
- R3: Each frame opens with fifteen nibbles of 0x5 followed by one nibble of 0xD on `txd`. This is seven 0x55 bytes and a 0xD5 delimiter, each byte sent low nibble first.
- R4: Fourteen header bytes follow, each sent low nibble first, in this order: six bytes of 0xFF, the six bytes of SRC_MAC (most significant byte first), then the two bytes of ETH_TYPE (most significant byte first).
- R5: The payload is exactly PAYLOAD_LEN bytes, taken in FIFO order from `fifo_data`, each sent low nibble first.
- R6: FIFO access works as follows:
  - `fifo_data` shows the oldest stored byte.
  - A high `fifo_rd` at a clock edge removes that byte.
  - `fifo_rd` pulses once per payload byte, and only while that byte's high nibble is being selected.
  - `fifo_rd` never fires outside the payload.
- R7: The last four bytes carry the CRC-32 over header and payload (reflected polynomial 0xEDB88320, initial value all ones, final inversion), least significant byte first, low nibble first.
- R8: `tx_en` is high without a break for exactly 2*(26+PAYLOAD_LEN) clocks per frame, and `txd` carries the frame nibbles in those cycles.
- R9: Between frames, `tx_en` stays low for at least IFG_CYCLES clocks. When a full payload is already waiting at the end of the gap, it stays low for exactly IFG_CYCLES clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PHY-supplied transmit clock |
| rst | input | 1 | Synchronous reset, active high |
| fifo_level | input | LVL_W | Number of bytes held in the upstream FIFO |
| fifo_data | input | 8 | Oldest byte in the FIFO (first-word fall-through) |
| fifo_rd | output | 1 | Pop the oldest FIFO byte at this clock edge |
| txd | output | 4 | MII transmit nibble |
| tx_en | output | 1 | MII transmit enable |

## Verification
The bench targets the following corner cases:

- **Fill level one byte short of a payload.** A framer that compared with the wrong bound would start early, read past the data, and send a short or stale payload.
- **Back-to-back frames.** An off-by-one in the gap counter shows up directly as 23 or 25 quiet cycles.
- **Reset in the middle of the payload.** A framer that kept CRC state across the reset would corrupt the check sequence of the following frame.
- **Payloads of all zeros, all ones and random bytes.** These expose nibble-order swaps and CRC bit-order mistakes that an incrementing pattern could hide.

// File: rtl/mii_tx_framer.sv
module mii_tx_framer #(
  parameter int          PAYLOAD_LEN = 46,
  parameter logic [47:0] SRC_MAC     = 48'h02_12_34_56_78_9A,
  parameter logic [15:0] ETH_TYPE    = 16'h88B5,
  parameter int          IFG_CYCLES  = 24,
  parameter int          LVL_W       = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic [7:0]       fifo_data,
  output logic             fifo_rd,
  output logic [3:0]       txd,
  output logic             tx_en
);

  localparam int CMAX = (2*PAYLOAD_LEN > IFG_CYCLES) ? 2*PAYLOAD_LEN : IFG_CYCLES;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int GW   = $clog2(IFG_CYCLES + 1);
  localparam logic [111:0] HDR = {48'hFFFF_FFFF_FFFF, SRC_MAC, ETH_TYPE};

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_HDR, S_PAY, S_FCS, S_GAP} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [31:0]   crc;
  logic [3:0]    nib;
  logic [111:0]  hsh;
  logic [7:0]    hbyte;
  logic          ready;
  logic          active;

  function automatic logic [31:0] crc_nib(input logic [31:0] c, input logic [3:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 4; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ 32'hEDB88320;
      else             r = r >> 1;
    end
    return r;
  endfunction

  assign ready   = fifo_level >= LVL_W'(PAYLOAD_LEN);
  assign active  = (st == S_PRE) || (st == S_HDR) || (st == S_PAY) || (st == S_FCS);
  assign hsh     = HDR >> (7'd104 - {cnt[4:1], 3'b000});
  assign hbyte   = hsh[7:0];
  assign fifo_rd = (st == S_PAY) && cnt[0];

  always_comb begin
    case (st)
      S_PRE:   nib = (cnt == CW'(15)) ? 4'hD : 4'h5;
      S_HDR:   nib = cnt[0] ? hbyte[7:4] : hbyte[3:0];
      S_PAY:   nib = cnt[0] ? fifo_data[7:4] : fifo_data[3:0];
      S_FCS:   nib = ~crc[3:0];
      default: nib = 4'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= S_IDLE;
      cnt   <= '0;
      crc   <= '1;
      txd   <= 4'h0;
      tx_en <= 1'b0;
    end else begin
      txd   <= active ? nib : 4'h0;
      tx_en <= active;
      cnt   <= cnt + 1'b1;
      case (st)
        S_IDLE: begin
          cnt <= '0;
          crc <= '1;
          if (ready) st <= S_PRE;
        end
        S_PRE: begin
          crc <= '1;
          if (cnt == CW'(15)) begin st <= S_HDR; cnt <= '0; end
        end
        S_HDR: begin
          crc <= crc_nib(crc, nib);
          if (cnt == CW'(27)) begin st <= S_PAY; cnt <= '0; end
        end
        S_PAY: begin
          crc <= crc_nib(crc, nib);
          if (cnt == CW'(2*PAYLOAD_LEN-1)) begin st <= S_FCS; cnt <= '0; end
        end
        S_FCS: begin
          crc <= crc >> 4;
          if (cnt == CW'(7)) begin st <= S_GAP; cnt <= '0; end
        end
        default: begin
          if (cnt == CW'(IFG_CYCLES-1)) begin
            cnt <= '0;
            st  <= ready ? S_PRE : S_IDLE;
          end
        end
      endcase
    end
  end

  logic [GW-1:0] gap_run;
  always_ff @(posedge clk) begin
    if (rst)                                 gap_run <= GW'(IFG_CYCLES);
    else if (tx_en)                          gap_run <= '0;
    else if (gap_run < GW'(IFG_CYCLES))      gap_run <= gap_run + 1'b1;
  end

  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> (!tx_en && !fifo_rd));
  a_r2_start_gated: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_en) |-> $past(fifo_level, 2) >= LVL_W'(PAYLOAD_LEN));
  a_r3_first_nibble: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_en) |-> txd == 4'h5);
  a_r6_rd_in_frame: assert property (@(posedge clk) disable iff (rst)
    fifo_rd |-> (tx_en && fifo_level != '0));
  a_r9_gap_kept: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_en) |-> gap_run >= GW'(IFG_CYCLES));

endmodule

// File: tb/mii_tx_framer_tb.sv
module mii_tx_framer_tb;
  localparam int          N    = 46;
  localparam logic [47:0] SRC  = 48'hA2_B4_C6_D8_EA_FC;
  localparam logic [15:0] TYP  = 16'h1357;
  localparam int          IFG  = 24;
  localparam int          FLEN = 2*(26+N);

  logic clk = 0, rst = 1;
  logic [11:0] fifo_level;
  logic [7:0] fifo_data;
  logic fifo_rd;
  logic [3:0] txd;
  logic tx_en;

  always #4 clk = ~clk;

  logic [7:0] mem [0:1023];
  int wr_ptr = 0, rd_ptr = 0;
  assign fifo_level = 12'(wr_ptr - rd_ptr);
  assign fifo_data  = mem[rd_ptr % 1024];
  always @(posedge clk) if (!rst && fifo_rd) rd_ptr <= rd_ptr + 1;

  mii_tx_framer #(.PAYLOAD_LEN(N), .SRC_MAC(SRC), .ETH_TYPE(TYP), .IFG_CYCLES(IFG), .LVL_W(12))
    u_dut (.clk(clk), .rst(rst), .fifo_level(fifo_level), .fifo_data(fifo_data),
           .fifo_rd(fifo_rd), .txd(txd), .tx_en(tx_en));

  int total = 0, bad = 0, frames = 0;

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r = c;
    for (int i = 0; i < 8; i++) r = ((r ^ 32'(b[i])) & 1) != 0 ? (r >> 1) ^ 32'hEDB88320 : r >> 1;
    return r;
  endfunction

  function automatic logic [7:0] hdr_byte(input int i);
    logic [111:0] h = {48'hFFFF_FFFF_FFFF, SRC, TYP};
    return h[8*(13-i) +: 8];
  endfunction

  logic [3:0] nibs [0:511];
  int  ncnt = 0, low_cnt = 0, start_ptr = 0;
  bit  in_frame = 0, have_prev = 0, prev_ready = 0;

  task automatic check_frame();
    logic [7:0] b [0:255];
    logic [31:0] c;
    int e3 = -1, e4 = -1, e5 = -1;
    chk(ncnt == FLEN, "R8", "frame nibble count", ncnt, FLEN);
    for (int i = 0; i < 256; i++) b[i] = (2*i+1 < ncnt) ? {nibs[2*i+1], nibs[2*i]} : 8'h00;
    for (int i = 0; i < 8; i++)  if (e3 < 0 && b[i] != (i == 7 ? 8'hD5 : 8'h55)) e3 = i;
    chk(e3 < 0, "R3", "preamble byte", e3 < 0 ? 0 : b[e3], e3 < 0 ? 0 : (e3 == 7 ? 8'hD5 : 8'h55));
    for (int i = 0; i < 14; i++) if (e4 < 0 && b[8+i] != hdr_byte(i)) e4 = i;
    chk(e4 < 0, "R4", "header byte", e4 < 0 ? 0 : b[8+e4], e4 < 0 ? 0 : hdr_byte(e4));
    for (int i = 0; i < N; i++) if (e5 < 0 && b[22+i] != mem[(start_ptr+i) % 1024]) e5 = i;
    chk(e5 < 0, "R5", "payload byte", e5 < 0 ? 0 : b[22+e5], e5 < 0 ? 0 : mem[(start_ptr+e5) % 1024]);
    chk(rd_ptr - start_ptr == N, "R6", "bytes popped", rd_ptr - start_ptr, N);
    c = '1;
    for (int i = 8; i < 22+N; i++) c = crc_byte(c, b[i]);
    c = ~c;
    chk({b[25+N], b[24+N], b[23+N], b[22+N]} == c, "R7", "fcs",
        {b[25+N], b[24+N], b[23+N], b[22+N]}, c);
  endtask

  always @(negedge clk) begin
    if (rst) begin
      in_frame <= 0; have_prev <= 0; low_cnt <= 0;
    end else if (tx_en) begin
      if (!in_frame) begin
        if (have_prev) begin
          if (prev_ready) chk(low_cnt == IFG, "R9", "back-to-back gap", low_cnt, IFG);
          else            chk(low_cnt >= IFG, "R9", "minimum gap", low_cnt, IFG);
        end
        chk(fifo_level >= 12'(N) || rd_ptr == start_ptr, "R2", "level at start", fifo_level, N);
        start_ptr = rd_ptr;
        ncnt = 0;
        in_frame <= 1;
      end
      if (ncnt < 512) nibs[ncnt] = txd;
      ncnt++;
      low_cnt <= 0;
    end else begin
      if (in_frame) begin
        check_frame();
        frames++;
        have_prev <= 1;
        prev_ready <= (fifo_level >= 12'(N));
        in_frame <= 0;
        low_cnt <= 1;
      end else low_cnt <= low_cnt + 1;
    end
  end

  task automatic push(input logic [7:0] v);
    mem[wr_ptr % 1024] = v;
    wr_ptr++;
  endtask

  task automatic wait_frames(input int k);
    while (frames < k) @(negedge clk);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      bad++; total++;
      $display("FAIL watchdog: got %0d expected below %0d", cyc, 50000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(tx_en == 0, "R1", "tx_en after reset", tx_en, 0);
    chk(fifo_rd == 0, "R1", "fifo_rd after reset", fifo_rd, 0);
    chk(txd == 0, "R1", "txd after reset", txd, 0);

    for (int i = 0; i < N-1; i++) push(8'(i*7+3));
    repeat (150) @(negedge clk);
    chk(frames == 0 && !in_frame, "R2", "no frame one byte short", frames, 0);
    chk(tx_en == 0, "R2", "tx_en while short", tx_en, 0);
    push(8'hC3);
    wait_frames(1);

    for (int i = 0; i < N; i++) push(8'hFF);
    for (int i = 0; i < N; i++) push(8'h00);
    for (int i = 0; i < N; i++) push(8'($urandom));
    for (int i = 0; i < N; i++) push(8'(i ^ 8'hA5));
    wait_frames(5);
    repeat (40) @(negedge clk);
    chk(tx_en == 0 && fifo_level == 0, "R2", "idle after drain", fifo_level, 0);

    for (int i = 0; i < 2*N; i++) push(8'($urandom));
    while (!tx_en) @(negedge clk);
    repeat (60) @(negedge clk);
    rst = 1;
    @(negedge clk);
    chk(tx_en == 0, "R1", "tx_en after mid-frame reset", tx_en, 0);
    chk(fifo_rd == 0, "R1", "fifo_rd after mid-frame reset", fifo_rd, 0);
    rst = 0;
    wait_frames(6);
    repeat (200) @(negedge clk);
    chk(frames == 6 && tx_en == 0, "R2", "leftover below payload", frames, 6);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule